// File: doc/BRIEF.md
# Asynchronous SRAM Bus Cycle Controller

This block sits between a synchronous host and an 8K×8 asynchronous static RAM. The host offers one request at a time over a valid/ready handshake: address, read-or-write and write data. The controller then runs one complete bus cycle on the memory pins. Those pins are 13 address lines, a data bus split into drive value, drive enable and sampled input, and active-low chip enable, output enable and write enable. When the cycle ends it returns a one-cycle done pulse, with the read byte when the request was a read.

Each cycle has phases: enable pulse, data setup, data hold, address hold, and bus release after a read. Every phase lasts a whole number of clocks. That number is taken at elaboration from a nanosecond minimum and the clock period, rounded up. A write-inhibit input, for example from a power-fail monitor, blocks writes. A write offered while it is high is refused with an error. If it rises during a write pulse, the pulse is cut short. Reads run whether or not it is high.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, chip enable, output enable and write enable are high, the data drive enable is low, req_ready is high and rsp_done is low.
- R2: An accepted read pulls chip enable and output enable low from the accepting edge, with write enable high. They stay low for N_RD = max(ceil(T_AA/CLK), ceil(T_OA/CLK), ceil(T_RC/CLK)) clocks (10 by default). The byte on the data input at the last of those edges is the one returned.
- R3: After a read's enables rise, the data drive enable stays low and no new cycle starts for N_RREC = max(ceil(T_CZ/CLK), ceil(T_OZ/CLK), ceil(T_AH/CLK), 1) clocks (5 by default).
- R4: An accepted write pulls chip enable and write enable low from the accepting edge, with output enable high. The address is valid from the same edge. The pulse lasts N_WP = max(ceil(T_WP/CLK), ceil(T_AW/CLK), ceil(T_DS/CLK), 1) clocks (8 by default).
- R5: During a write, the data drive enable is high for the whole pulse and for N_DH = ceil(T_DH/CLK) clocks after it (1 by default), and is low at all other times. The driven byte is the request's write data.
- R6: After a write pulse, the address stays unchanged and no new cycle starts for N_WREC = max(ceil(T_AH/CLK), N_DH, N_RC − N_WP, 1) clocks (2 by default).
- R7: Output enable is never low while write enable is low or while the data drive enable is high.
- R8: rsp_done is a single-cycle pulse, in the cycle after recovery ends. req_ready is low from the accepting edge until that pulse.
- R9: A write offered in an idle cycle with wr_inhibit high produces rsp_done and rsp_err in the next cycle and no enable pulse. The addressed byte keeps its old value.
- R10: If wr_inhibit is high at an edge during a write pulse, chip and write enable rise at that edge. The write recovery of R6 still follows, and the done pulse carries rsp_err high.
- R11: A read offered while wr_inhibit is high runs as in R2 and R3 and ends with rsp_err low.
- R12: The address and the driven write byte do not change while chip enable is low or while the data drive enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| wr_inhibit | input | 1 | Blocks and cuts short writes |
| rsp_done | output | 1 | One-cycle end-of-request pulse |
| rsp_err | output | 1 | Write refused or cut short, valid with rsp_done |
| rsp_rdata | output | DATA_W | Byte from the last read |
| sram_addr | output | ADDR_W | Memory address lines |
| sram_dq_o | output | DATA_W | Byte to drive on the data bus |
| sram_dq_oe | output | 1 | Data bus drive enable |
| sram_dq_i | input | DATA_W | Byte sampled from the data bus |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |

## Verification
The bench writes to the lowest address, the highest address and a middle address, with complementary and alternating bit patterns. It then reads them back. Wrong addressing or a lost byte shows up as a mismatch. Its memory model returns the inverted byte until the access times have passed, so a read that samples early fails. Three inhibit cases are run: a refused write followed by a read-back, a read while inhibit is high, and a write cut short after three pulse clocks. These separate refusal, early termination and normal reads. A write right after a read, and a read right after a write, test the turnaround and hold phases.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RD_REC,
        ST_WR,
        ST_WR_REC
    } phase_e;

    // Nanosecond minimum to whole clocks, rounded up
    function automatic int unsigned ns_to_clk(int unsigned ns, int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic [CW-1:0] cnt_o,
    output logic          zero_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_i,
    input  logic [DW-1:0] dq_i,
    output logic [DW-1:0] rdata_o
);

    logic [DW-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (cap_i) begin
            rdata_d = dq_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W  = 13,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned CLK_NS  = 10,
    parameter int unsigned T_RC_NS = 100,
    parameter int unsigned T_AA_NS = 100,
    parameter int unsigned T_OA_NS = 50,
    parameter int unsigned T_WP_NS = 80,
    parameter int unsigned T_AW_NS = 80,
    parameter int unsigned T_DS_NS = 50,
    parameter int unsigned T_DH_NS = 5,
    parameter int unsigned T_AH_NS = 10,
    parameter int unsigned T_CZ_NS = 50,
    parameter int unsigned T_OZ_NS = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              wr_inhibit,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_i,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n
);

    localparam int unsigned N_RC   = ns_to_clk(T_RC_NS, CLK_NS);
    localparam int unsigned N_AA   = ns_to_clk(T_AA_NS, CLK_NS);
    localparam int unsigned N_OA   = ns_to_clk(T_OA_NS, CLK_NS);
    localparam int unsigned N_AH   = ns_to_clk(T_AH_NS, CLK_NS);
    localparam int unsigned N_CZ   = ns_to_clk(T_CZ_NS, CLK_NS);
    localparam int unsigned N_OZ   = ns_to_clk(T_OZ_NS, CLK_NS);
    localparam int unsigned N_DH   = ns_to_clk(T_DH_NS, CLK_NS);
    localparam int unsigned N_RD   = max2(max2(N_AA, N_OA), max2(N_RC, 1));
    localparam int unsigned N_RREC = max2(max2(N_CZ, N_OZ), max2(N_AH, 1));
    localparam int unsigned N_WPL  = max2(max2(ns_to_clk(T_WP_NS, CLK_NS),
                                               ns_to_clk(T_AW_NS, CLK_NS)),
                                          max2(ns_to_clk(T_DS_NS, CLK_NS), 1));
    localparam int unsigned N_WGAP = (N_RC > N_WPL) ? (N_RC - N_WPL) : 0;
    localparam int unsigned N_WREC = max2(max2(N_AH, N_DH), max2(N_WGAP, 1));
    localparam int unsigned N_MAX  = max2(max2(N_RD, N_RREC), max2(N_WPL, N_WREC));
    localparam int unsigned CW     = $clog2(N_MAX + 1);

    typedef struct packed {
        phase_e              ph;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic                ce_n;
        logic                oe_n;
        logic                we_n;
        logic                dq_oe;
        logic                done;
        logic                err;
        logic                abort;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        ph: ST_IDLE, addr: '0, wdata: '0, ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
        dq_oe: 1'b0, done: 1'b0, err: 1'b0, abort: 1'b0
    };

    ctl_t          r_d, r_q;
    logic          t_load;
    logic [CW-1:0] t_val;
    logic [CW-1:0] t_cnt;
    logic          t_zero;
    logic          cap;
    logic [CW:0]   rec_idx;

    sram_phase_cnt #(.CW(CW)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (t_load),
        .load_val_i (t_val),
        .cnt_o      (t_cnt),
        .zero_o     (t_zero)
    );

    sram_rd_capture #(.DW(DATA_W)) i_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   (cap),
        .dq_i    (sram_dq_i),
        .rdata_o (rsp_rdata)
    );

    // Position inside write recovery of the cycle being computed
    assign rec_idx = (CW+1)'(N_WREC) - {1'b0, t_cnt};

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        t_load   = 1'b0;
        t_val    = '0;
        cap      = 1'b0;
        unique case (r_q.ph)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_write && wr_inhibit) begin
                        r_d.done = 1'b1;
                        r_d.err  = 1'b1;
                    end else begin
                        r_d.addr  = req_addr;
                        r_d.wdata = req_wdata;
                        r_d.ce_n  = 1'b0;
                        r_d.abort = 1'b0;
                        t_load    = 1'b1;
                        if (req_write) begin
                            r_d.we_n  = 1'b0;
                            r_d.dq_oe = 1'b1;
                            r_d.ph    = ST_WR;
                            t_val     = CW'(N_WPL - 1);
                        end else begin
                            r_d.oe_n = 1'b0;
                            r_d.ph   = ST_RD;
                            t_val    = CW'(N_RD - 1);
                        end
                    end
                end
            end
            ST_RD: begin
                if (t_zero) begin
                    cap      = 1'b1;
                    r_d.ce_n = 1'b1;
                    r_d.oe_n = 1'b1;
                    r_d.ph   = ST_RD_REC;
                    t_load   = 1'b1;
                    t_val    = CW'(N_RREC - 1);
                end
            end
            ST_RD_REC: begin
                if (t_zero) begin
                    r_d.ph   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
            ST_WR: begin
                if (t_zero || wr_inhibit) begin
                    r_d.ce_n  = 1'b1;
                    r_d.we_n  = 1'b1;
                    r_d.dq_oe = (N_DH > 0);
                    r_d.abort = wr_inhibit;
                    r_d.ph    = ST_WR_REC;
                    t_load    = 1'b1;
                    t_val     = CW'(N_WREC - 1);
                end
            end
            ST_WR_REC: begin
                r_d.dq_oe = (rec_idx < (CW+1)'(N_DH));
                if (t_zero) begin
                    r_d.dq_oe = 1'b0;
                    r_d.ph    = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.err   = r_q.abort;
                end
            end
            default: r_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= CTL_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.ph == ST_IDLE);
    assign rsp_done   = r_q.done;
    assign rsp_err    = r_q.err;
    assign sram_addr  = r_q.addr;
    assign sram_dq_o  = r_q.wdata;
    assign sram_dq_oe = r_q.dq_oe;
    assign sram_ce_n  = r_q.ce_n;
    assign sram_oe_n  = r_q.oe_n;
    assign sram_we_n  = r_q.we_n;

    // ---------------- assertions ----------------
    logic [CW-1:0] gap_q;   // clocks since output enable was last low
    logic [CW-1:0] wpw_q;   // clocks write enable has been low

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= CW'(N_RREC);
            wpw_q <= '0;
        end else begin
            if (!sram_oe_n) begin
                gap_q <= '0;
            end else if (gap_q < CW'(N_RREC)) begin
                gap_q <= gap_q + 1'b1;
            end
            if (!sram_we_n) begin
                if (wpw_q < CW'(N_MAX)) wpw_q <= wpw_q + 1'b1;
            end else begin
                wpw_q <= '0;
            end
        end
    end

    p_oe_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (sram_we_n && !sram_dq_oe));

    p_we_inside_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> !sram_ce_n);

    p_pulse_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> ((wpw_q >= CW'(N_WPL)) || rsp_err || r_q.abort));

    p_read_turnaround_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> (gap_q >= CW'(N_RREC)));

    p_addr_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

    p_wdata_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_o));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_done);

    p_reject_no_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && wr_inhibit) |=> (sram_ce_n && rsp_err));

endmodule

// File: tb/test_sram_cycle_ctrl.sv
`timescale 1ns/100ps
module test_sram_cycle_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int T_RC = 100, T_AA = 100, T_OA = 50, T_WP = 80, T_AW = 80;
    localparam int T_DS = 50, T_DH = 5, T_AH = 10, T_CZ = 50, T_OZ = 40;

    function automatic int cl(int ns);
        return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    endfunction
    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_RD   = mx(mx(cl(T_AA), cl(T_OA)), mx(cl(T_RC), 1));
    localparam int E_RREC = mx(mx(cl(T_CZ), cl(T_OZ)), mx(cl(T_AH), 1));
    localparam int E_WP   = mx(mx(cl(T_WP), cl(T_AW)), mx(cl(T_DS), 1));
    localparam int E_DH   = cl(T_DH);
    localparam int E_WREC = mx(mx(cl(T_AH), E_DH), mx(mx(cl(T_RC) - E_WP, 0), 1));

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, wr_inhibit = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_done, rsp_err;
    logic [7:0]  rsp_rdata;
    logic [12:0] sram_addr;
    logic [7:0]  sram_dq_o, sram_dq_i;
    logic        sram_dq_oe, sram_ce_n, sram_oe_n, sram_we_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_cycle_ctrl i_sram_cycle_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .wr_inhibit(wr_inhibit), .rsp_done(rsp_done), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .sram_addr(sram_addr), .sram_dq_o(sram_dq_o),
        .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i), .sram_ce_n(sram_ce_n),
        .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
    );

    int checks = 0;
    int fails  = 0;
    bit running = 1'b0;

    // ---- behavioural memory with access-time model ----
    logic [7:0] phys [int];
    logic [7:0] ref_mem [int];
    realtime t_ce, t_oe, t_adr;

    function automatic logic [7:0] phys_rd(int a);
        return phys.exists(a) ? phys[a] : 8'h00;
    endfunction

    initial begin
        logic ce_p, oe_p, wr_p;
        logic [12:0] a_p;
        bit ok;
        ce_p = 1'b1; oe_p = 1'b1; wr_p = 1'b0; a_p = '0;
        t_ce = 0; t_oe = 0; t_adr = 0;
        sram_dq_i = 8'h5A;
        #0.5;
        forever begin
            if (!sram_ce_n && ce_p) t_ce = $realtime;
            if (!sram_oe_n && oe_p) t_oe = $realtime;
            if (sram_addr != a_p)   t_adr = $realtime;
            if (wr_p && !(!sram_ce_n && !sram_we_n)) phys[int'(a_p)] = sram_dq_o;
            if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
                ok = ($realtime - t_ce  >= T_AA - CLK_PERIOD/2) &&
                     ($realtime - t_oe  >= T_OA - CLK_PERIOD/2) &&
                     ($realtime - t_adr >= T_AA - CLK_PERIOD/2);
                sram_dq_i = ok ? phys_rd(int'(sram_addr)) : ~phys_rd(int'(sram_addr));
            end else begin
                sram_dq_i = 8'h5A;
            end
            ce_p = sram_ce_n; oe_p = sram_oe_n; a_p = sram_addr;
            wr_p = !sram_ce_n && !sram_we_n;
            #1;
        end
    end

    // ---- expected per-cycle stream ----
    typedef struct {
        logic ce, oe, we, dqoe, done, err, rdy;
        bit achk; logic [12:0] addr;
        bit dchk; logic [7:0] dq;
        bit rchk; logic [7:0] rd;
        string tag;
    } exp_t;

    exp_t q[$];

    function automatic exp_t idle_e(string tag);
        exp_t e;
        e.ce = 1; e.oe = 1; e.we = 1; e.dqoe = 0; e.done = 0; e.err = 0; e.rdy = 1;
        e.achk = 0; e.addr = '0; e.dchk = 0; e.dq = '0; e.rchk = 0; e.rd = '0;
        e.tag = tag;
        return e;
    endfunction

    always @(negedge clk) begin
        exp_t e;
        bit ok;
        if (rst_n && running) begin
            e = (q.size() != 0) ? q.pop_front() : idle_e("R8");
            ok = (sram_ce_n === e.ce) && (sram_oe_n === e.oe) && (sram_we_n === e.we) &&
                 (sram_dq_oe === e.dqoe) && (rsp_done === e.done) && (rsp_err === e.err) &&
                 (req_ready === e.rdy);
            if (e.achk && sram_addr !== e.addr) ok = 0;
            if (e.dchk && sram_dq_o !== e.dq)   ok = 0;
            if (e.rchk && rsp_rdata !== e.rd)   ok = 0;
            checks++;
            if (!ok) begin
                fails++;
                $display("FAIL %s t=%0t ce/oe/we/dqoe/done/err/rdy got %b%b%b%b%b%b%b exp %b%b%b%b%b%b%b addr %h/%h dq %h/%h rd %h/%h",
                    e.tag, $time, sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, rsp_done, rsp_err,
                    req_ready, e.ce, e.oe, e.we, e.dqoe, e.done, e.err, e.rdy,
                    sram_addr, e.addr, sram_dq_o, e.dq, rsp_rdata, e.rd);
            end
        end
    end

    task automatic settle();
        while (q.size() != 0) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic do_read(input logic [12:0] a, input string tag);
        exp_t e;
        @(negedge clk); #1;
        req_valid = 1; req_write = 0; req_addr = a;
        for (int i = 0; i < E_RD; i++) begin
            e = idle_e(tag); e.ce = 0; e.oe = 0; e.rdy = 0; e.achk = 1; e.addr = a;
            q.push_back(e);
        end
        for (int i = 0; i < E_RREC; i++) begin
            e = idle_e("R3"); e.rdy = 0; e.achk = 1; e.addr = a;
            q.push_back(e);
        end
        e = idle_e(tag); e.done = 1; e.rchk = 1;
        e.rd = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
        q.push_back(e);
        @(negedge clk); #1;
        req_valid = 0;
        settle();
    endtask

    // cut = 0: full pulse; cut = m > 0: inhibit seen after m pulse clocks (R10)
    task automatic do_write(input logic [12:0] a, input logic [7:0] d, input int cut);
        exp_t e;
        int act;
        act = (cut == 0) ? E_WP : cut;
        @(negedge clk); #1;
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        for (int i = 0; i < act; i++) begin
            e = idle_e((cut == 0) ? "R4" : "R10"); e.ce = 0; e.we = 0; e.dqoe = 1; e.rdy = 0;
            e.achk = 1; e.addr = a; e.dchk = 1; e.dq = d;
            q.push_back(e);
        end
        for (int i = 0; i < E_WREC; i++) begin
            e = idle_e((i < E_DH) ? "R5" : "R6"); e.rdy = 0; e.dqoe = (i < E_DH);
            e.achk = 1; e.addr = a; e.dchk = (i < E_DH); e.dq = d;
            q.push_back(e);
        end
        e = idle_e((cut == 0) ? "R8" : "R10"); e.done = 1; e.err = (cut != 0);
        q.push_back(e);
        if (cut == 0) ref_mem[int'(a)] = d;
        @(negedge clk); #1;
        req_valid = 0;
        if (cut != 0) begin
            for (int i = 1; i < cut; i++) begin
                @(negedge clk); #1;
            end
            wr_inhibit = 1;
        end
        settle();
        wr_inhibit = 0;
    endtask

    task automatic do_reject(input logic [12:0] a, input logic [7:0] d);
        exp_t e;
        @(negedge clk); #1;
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; wr_inhibit = 1;
        e = idle_e("R9"); e.done = 1; e.err = 1;
        q.push_back(e);
        @(negedge clk); #1;
        req_valid = 0;
        settle();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: got hung run, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state under reset
        checks++;
        if ({sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, req_ready, rsp_done} !== 6'b111010) begin
            fails++;
            $display("FAIL R1 reset got %b exp 111010",
                {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, req_ready, rsp_done});
        end
        #1 rst_n = 1;
        @(negedge clk);
        checks++;
        if ({sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, req_ready, rsp_done} !== 6'b111010) begin
            fails++;
            $display("FAIL R1 after release got %b exp 111010",
                {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, req_ready, rsp_done});
        end
        running = 1;

        do_write(13'h0000, 8'h3C, 0);
        do_write(13'h1FFF, 8'hC3, 0);
        do_write(13'h0AAA, 8'h55, 0);
        do_read (13'h0000, "R2");
        do_read (13'h1FFF, "R2");
        do_read (13'h0AAA, "R2");

        do_reject(13'h0AAA, 8'hFF);         // R9: must leave 0x55
        do_read (13'h0AAA, "R11");          // inhibit still high: R11
        wr_inhibit = 0;
        do_read (13'h0AAA, "R9");

        do_write(13'h0123, 8'h99, 3);       // R10: cut short after 3 clocks
        do_write(13'h0777, 8'hA5, 0);
        do_read (13'h0777, "R2");
        do_write(13'h0777, 8'h5A, 0);       // write right after read: R3
        do_read (13'h0777, "R12");
        do_write(13'h1000, 8'h01, 0);
        do_write(13'h0001, 8'h80, 0);
        do_read (13'h1000, "R2");
        do_read (13'h0001, "R2");
        repeat (4) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule